// File: doc/BRIEF.md
# PCI Master Bus Sequencer

This block runs the bus side of a PCI initiator. A backend states whether a transfer is wanted and how it should go: address stepping, last data phase, data ready, locked access, whether the previous transfer was a write, and whether the next target is the same one. The block requests the bus. Once it is granted, it runs the address phase and the data phases. It drives FRAME#, IRDY#, LOCK#, PAR and PERR# with their output enables. It also produces the enables for the AD and C/BE# lines, and it keeps those lines driven while the bus is parked on this agent.

Two results go back to the backend: a master abort, raised when no target claims the transfer in time, and a target abort. A separate two-state monitor follows LOCK# on the bus, so that a locked request is not made while another agent holds the lock. A one-bit register tracks whether this agent owns the lock. Bus inputs are the sampled bus values. Outputs are formed from the registered state and those samples.

Top module: `pci_master_seq`

## Requirements
- R1: Out of reset the sequencer is idle, with REQ#, FRAME#, IRDY# and LOCK# deasserted (1) and every output enable low. From idle, when GNT# is low and FRAME# and IRDY# are both high, it starts an address phase if a request without stepping is pending. Otherwise it parks. In all other cases it stays idle.
- R2: The address phase lasts exactly one clock, drives FRAME# low, and is always followed by a data phase.
- R3: A data phase repeats while bus FRAME# is low, or while FRAME#, TRDY# and STOP# are all high and no devsel timeout is present. Failing that, it goes to the stopped state when STOP# is low or the timeout is present. Failing that, it starts a new address phase at once if a request without stepping is pending, GNT# is low, TRDY# is low, the previous transfer was a write, and either same-target or fast back-to-back enable is set. Otherwise it goes to turnaround.
- R4: From turnaround or park, GNT# high leads to idle. With GNT# low, a request without stepping leads to an address phase, and anything else leads to park. The stopped state lasts one clock and leads to park when GNT# is low, or to idle otherwise.
- R5: In a data phase with no devsel timeout, FRAME# is low when one of two things holds: the last phase is not flagged, STOP# is high, and either the latency timer has not expired or GNT# is low; or ready is low. IRDY# is low in a data phase when ready is set or the devsel timeout is present.
- R6: The devsel timer restarts at every address phase. If DEVSEL# has not been seen low in the first 5 data-phase clocks, the timeout is present from the 6th onward. Master abort is the timeout during a data phase.
- R7: Target abort is flagged in a data phase when STOP# is low, DEVSEL# is high, FRAME# is high and IRDY# is low.
- R8: REQ# is low when a request is pending. For a locked request, the lock monitor must also be free. REQ# is held high in the stopped state and on the clock after it.
- R9: The FRAME# enable covers the address and data phases. The C/BE# enable covers the address phase, data phases and park. The AD enable covers the address phase, data phases of writes, and park. park_addr_o is high in park when stepping and a request are both set. The IRDY# enable is high when the previous state was an address or data phase.
- R10: PAR equals the XOR of the AD and C/BE# lines from the previous clock. The PAR enable is the AD enable delayed by one clock. PERR# is low exactly while the report input is high, and its enable covers that clock and the next.
- R11: The lock monitor becomes busy when LOCK# is low and this agent does not own the lock. It becomes free again only when LOCK# and FRAME# are both high.
- R12: Lock ownership is set when LOCK#, FRAME# and IRDY# are high, GNT# is low, and a locked request is pending. It is kept while FRAME# or LOCK# is low. An owner drives LOCK# low during data phases. The LOCK# enable stays on after that while FRAME# or LOCK# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Backend has a transfer pending |
| step_i | input | 1 | Backend is stepping the address |
| last_phase_i | input | 1 | Current data phase is the last |
| ready_i | input | 1 | Backend ready to move data |
| locked_req_i | input | 1 | Pending request is a locked access |
| prev_write_i | input | 1 | Previous transfer was a write |
| same_tgt_i | input | 1 | Next transfer goes to the same target |
| fb2b_en_i | input | 1 | Fast back-to-back enable |
| lat_expired_i | input | 1 | Master latency timer expired |
| cmd_write_i | input | 1 | Current command is a write |
| perr_report_i | input | 1 | One-clock parity error report |
| ad_i | input | AD_W | Sampled AD lines |
| cbe_ni | input | CBE_W | Sampled C/BE# lines |
| gnt_ni | input | 1 | Bus grant, active low |
| frame_ni | input | 1 | Bus FRAME# |
| irdy_ni | input | 1 | Bus IRDY# |
| trdy_ni | input | 1 | Bus TRDY# |
| stop_ni | input | 1 | Bus STOP# |
| devsel_ni | input | 1 | Bus DEVSEL# |
| lock_ni | input | 1 | Bus LOCK# |
| req_no | output | 1 | Bus request, active low |
| frame_no | output | 1 | FRAME# drive value |
| frame_oe_o | output | 1 | FRAME# enable |
| irdy_no | output | 1 | IRDY# drive value |
| irdy_oe_o | output | 1 | IRDY# enable |
| lock_no | output | 1 | LOCK# drive value |
| lock_oe_o | output | 1 | LOCK# enable |
| cbe_oe_o | output | 1 | C/BE# enable |
| ad_oe_o | output | 1 | AD enable |
| park_addr_o | output | 1 | Parked bus carries address and command |
| par_o | output | 1 | Parity drive value |
| par_oe_o | output | 1 | Parity enable |
| perr_no | output | 1 | PERR# drive value |
| perr_oe_o | output | 1 | PERR# enable |
| master_abort_o | output | 1 | No target claimed the transfer |
| target_abort_o | output | 1 | Target aborted the transfer |

## Verification
The devsel timeout is the hardest case to reach from the ports. The bench has to hold FRAME# low and DEVSEL# high for six straight data phases after a fresh address phase. It gets there with a phase of stimulus that keeps GNT# and FRAME# low most of the time and rarely asserts DEVSEL#. Lock ownership needs LOCK#, FRAME# and IRDY# all high together with a grant and a locked request, so a separate phase biases the bus toward idle while locked requests are pending. A third phase favours write completions with TRDY# low, to reach the fast back-to-back path. A behavioural model follows the run and compares every output on every clock.

// File: rtl/pci_mseq_pkg.sv
package pci_mseq_pkg;
  typedef enum logic [2:0] {
    MS_IDLE = 3'd0,
    MS_ADDR = 3'd1,
    MS_XFER = 3'd2,
    MS_TURN = 3'd3,
    MS_HALT = 3'd4,
    MS_PARK = 3'd5
  } mseq_state_e;
endpackage

// File: rtl/pci_mseq_fsm.sv
module pci_mseq_fsm
  import pci_mseq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        step_i,
  input  logic        gnt_ni,
  input  logic        frame_ni,
  input  logic        irdy_ni,
  input  logic        trdy_ni,
  input  logic        stop_ni,
  input  logic        dev_to_i,
  input  logic        prev_write_i,
  input  logic        same_tgt_i,
  input  logic        fb2b_en_i,
  output mseq_state_e state_o,
  output logic        halt_prev_o
);
  mseq_state_e state_q, state_d;
  logic        start_ok, xfer_hold, xfer_stop, xfer_b2b;

  assign start_ok  = req_i & ~step_i;
  assign xfer_hold = ~frame_ni | (trdy_ni & stop_ni & ~dev_to_i);
  assign xfer_stop = frame_ni & (~stop_ni | dev_to_i);
  assign xfer_b2b  = start_ok & ~gnt_ni & frame_ni & ~trdy_ni & stop_ni &
                     prev_write_i & (same_tgt_i | fb2b_en_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MS_IDLE: if (!gnt_ni && frame_ni && irdy_ni)
                 state_d = start_ok ? MS_ADDR : MS_PARK;
      MS_ADDR: state_d = MS_XFER;
      MS_XFER: begin
        if (xfer_hold)      state_d = MS_XFER;
        else if (xfer_stop) state_d = MS_HALT;
        else if (xfer_b2b)  state_d = MS_ADDR;
        else                state_d = MS_TURN;
      end
      MS_TURN, MS_PARK: begin
        if (gnt_ni)        state_d = MS_IDLE;
        else if (start_ok) state_d = MS_ADDR;
        else               state_d = MS_PARK;
      end
      MS_HALT: state_d = gnt_ni ? MS_IDLE : MS_PARK;
      default: state_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= MS_IDLE;
      halt_prev_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      halt_prev_o <= (state_q == MS_HALT);
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/pci_mseq_devsel.sv
module pci_mseq_devsel
  import pci_mseq_pkg::*;
#(
  parameter int unsigned LIMIT = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  mseq_state_e state_i,
  input  logic        devsel_ni,
  output logic        timeout_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (state_i == MS_ADDR) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (state_i == MS_XFER) begin
      if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
      seen_q <= seen_q | ~devsel_ni;
    end
  end

  // data clocks 1..LIMIT are allowed for the claim
  assign timeout_o = (state_i == MS_XFER) & ~seen_q & (cnt_q == CMAX);
endmodule

// File: rtl/pci_mseq_lock.sv
module pci_mseq_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic locked_req_i,
  input  logic gnt_ni,
  input  logic frame_ni,
  input  logic irdy_ni,
  input  logic lock_ni,
  output logic owned_o,
  output logic busy_o
);
  logic own_q, own_d, busy_q, busy_d;

  assign own_d = (lock_ni & frame_ni & irdy_ni & ~gnt_ni & req_i & locked_req_i) |
                 (own_q & (~frame_ni | ~lock_ni));

  always_comb begin
    if (busy_q) busy_d = ~(lock_ni & frame_ni);
    else        busy_d = ~lock_ni & ~own_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      own_q  <= own_d;
      busy_q <= busy_d;
    end
  end

  assign owned_o = own_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/pci_mseq_drive.sv
module pci_mseq_drive
  import pci_mseq_pkg::*;
#(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mseq_state_e      state_i,
  input  logic             halt_prev_i,
  input  logic             dev_to_i,
  input  logic             owned_i,
  input  logic             busy_i,
  input  logic             req_i,
  input  logic             step_i,
  input  logic             last_phase_i,
  input  logic             ready_i,
  input  logic             locked_req_i,
  input  logic             lat_expired_i,
  input  logic             cmd_write_i,
  input  logic             perr_report_i,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_ni,
  input  logic             gnt_ni,
  input  logic             frame_ni,
  input  logic             irdy_ni,
  input  logic             stop_ni,
  input  logic             devsel_ni,
  input  logic             lock_ni,
  output logic             req_no,
  output logic             frame_no,
  output logic             frame_oe_o,
  output logic             irdy_no,
  output logic             irdy_oe_o,
  output logic             lock_no,
  output logic             lock_oe_o,
  output logic             cbe_oe_o,
  output logic             ad_oe_o,
  output logic             park_addr_o,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_no,
  output logic             perr_oe_o,
  output logic             master_abort_o,
  output logic             target_abort_o
);
  logic in_addr, in_xfer, in_park, in_halt;
  logic frame_keep, lock_drv, req_want;
  logic irdy_oe_q, lock_oe_q, par_oe_q, par_q, perr_q;

  assign in_addr = (state_i == MS_ADDR);
  assign in_xfer = (state_i == MS_XFER);
  assign in_park = (state_i == MS_PARK);
  assign in_halt = (state_i == MS_HALT);

  assign frame_keep = (~last_phase_i & (~lat_expired_i | ~gnt_ni) & stop_ni) | ~ready_i;
  assign frame_no   = ~(in_addr | (in_xfer & ~dev_to_i & frame_keep));
  assign irdy_no    = ~(in_xfer & (ready_i | dev_to_i));

  assign master_abort_o = in_xfer & dev_to_i;
  assign target_abort_o = in_xfer & ~stop_ni & devsel_ni & frame_ni & ~irdy_ni;

  // locked request waits for a free monitor; quiet for two clocks after a stop
  assign req_want = req_i & (~locked_req_i | ~busy_i);
  assign req_no   = ~(req_want & ~(in_halt | halt_prev_i));

  assign frame_oe_o  = in_addr | in_xfer;
  assign cbe_oe_o    = in_addr | in_xfer | in_park;
  assign ad_oe_o     = in_addr | (in_xfer & cmd_write_i) | in_park;
  assign park_addr_o = in_park & step_i & req_i;
  assign irdy_oe_o   = irdy_oe_q;

  assign lock_drv  = owned_i & in_xfer;
  assign lock_no   = ~lock_drv;
  assign lock_oe_o = lock_drv | (lock_oe_q & (~frame_ni | ~lock_ni));

  assign par_o     = par_q;
  assign par_oe_o  = par_oe_q;
  assign perr_no   = ~perr_report_i;
  assign perr_oe_o = perr_report_i | perr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irdy_oe_q <= 1'b0;
      lock_oe_q <= 1'b0;
      par_oe_q  <= 1'b0;
      par_q     <= 1'b0;
      perr_q    <= 1'b0;
    end else begin
      irdy_oe_q <= in_addr | in_xfer;
      lock_oe_q <= lock_oe_o;
      par_oe_q  <= ad_oe_o;
      par_q     <= ^{ad_i, cbe_ni};
      perr_q    <= perr_report_i;
    end
  end
endmodule

// File: rtl/pci_master_seq.sv
module pci_master_seq
  import pci_mseq_pkg::*;
#(
  parameter int unsigned AD_W         = 32,
  parameter int unsigned CBE_W        = 4,
  parameter int unsigned DEVSEL_LIMIT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             step_i,
  input  logic             last_phase_i,
  input  logic             ready_i,
  input  logic             locked_req_i,
  input  logic             prev_write_i,
  input  logic             same_tgt_i,
  input  logic             fb2b_en_i,
  input  logic             lat_expired_i,
  input  logic             cmd_write_i,
  input  logic             perr_report_i,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_ni,
  input  logic             gnt_ni,
  input  logic             frame_ni,
  input  logic             irdy_ni,
  input  logic             trdy_ni,
  input  logic             stop_ni,
  input  logic             devsel_ni,
  input  logic             lock_ni,
  output logic             req_no,
  output logic             frame_no,
  output logic             frame_oe_o,
  output logic             irdy_no,
  output logic             irdy_oe_o,
  output logic             lock_no,
  output logic             lock_oe_o,
  output logic             cbe_oe_o,
  output logic             ad_oe_o,
  output logic             park_addr_o,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_no,
  output logic             perr_oe_o,
  output logic             master_abort_o,
  output logic             target_abort_o
);
  mseq_state_e state_w;
  logic        halt_prev_w, dev_to_w, owned_w, busy_w;

  pci_mseq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .step_i       (step_i),
    .gnt_ni       (gnt_ni),
    .frame_ni     (frame_ni),
    .irdy_ni      (irdy_ni),
    .trdy_ni      (trdy_ni),
    .stop_ni      (stop_ni),
    .dev_to_i     (dev_to_w),
    .prev_write_i (prev_write_i),
    .same_tgt_i   (same_tgt_i),
    .fb2b_en_i    (fb2b_en_i),
    .state_o      (state_w),
    .halt_prev_o  (halt_prev_w)
  );

  pci_mseq_devsel #(.LIMIT(DEVSEL_LIMIT)) u_devsel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state_w),
    .devsel_ni (devsel_ni),
    .timeout_o (dev_to_w)
  );

  pci_mseq_lock u_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .locked_req_i (locked_req_i),
    .gnt_ni       (gnt_ni),
    .frame_ni     (frame_ni),
    .irdy_ni      (irdy_ni),
    .lock_ni      (lock_ni),
    .owned_o      (owned_w),
    .busy_o       (busy_w)
  );

  pci_mseq_drive #(.AD_W(AD_W), .CBE_W(CBE_W)) u_drive (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .state_i        (state_w),
    .halt_prev_i    (halt_prev_w),
    .dev_to_i       (dev_to_w),
    .owned_i        (owned_w),
    .busy_i         (busy_w),
    .req_i          (req_i),
    .step_i         (step_i),
    .last_phase_i   (last_phase_i),
    .ready_i        (ready_i),
    .locked_req_i   (locked_req_i),
    .lat_expired_i  (lat_expired_i),
    .cmd_write_i    (cmd_write_i),
    .perr_report_i  (perr_report_i),
    .ad_i           (ad_i),
    .cbe_ni         (cbe_ni),
    .gnt_ni         (gnt_ni),
    .frame_ni       (frame_ni),
    .irdy_ni        (irdy_ni),
    .stop_ni        (stop_ni),
    .devsel_ni      (devsel_ni),
    .lock_ni        (lock_ni),
    .req_no         (req_no),
    .frame_no       (frame_no),
    .frame_oe_o     (frame_oe_o),
    .irdy_no        (irdy_no),
    .irdy_oe_o      (irdy_oe_o),
    .lock_no        (lock_no),
    .lock_oe_o      (lock_oe_o),
    .cbe_oe_o       (cbe_oe_o),
    .ad_oe_o        (ad_oe_o),
    .park_addr_o    (park_addr_o),
    .par_o          (par_o),
    .par_oe_o       (par_oe_o),
    .perr_no        (perr_no),
    .perr_oe_o      (perr_oe_o),
    .master_abort_o (master_abort_o),
    .target_abort_o (target_abort_o)
  );
endmodule

// File: rtl/pci_master_seq_chk.sv
module pci_master_seq_chk
  import pci_mseq_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input mseq_state_e state_i,
  input logic        busy_i,
  input logic        own_i,
  input logic        gnt_ni,
  input logic        lock_ni,
  input logic        frame_ni,
  input logic        req_no,
  input logic        frame_no,
  input logic        master_abort_i,
  input logic        ad_oe_i,
  input logic        par_oe_i
);
  AST_IDLE_WITHOUT_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == MS_IDLE) && gnt_ni |=> (state_i == MS_IDLE)); // R1
  AST_ADDR_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == MS_ADDR) |=> (state_i == MS_XFER)); // R2
  AST_ADDR_FRAME_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == MS_ADDR) |-> !frame_no); // R2
  AST_HALT_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == MS_HALT) |=> (state_i == MS_IDLE || state_i == MS_PARK)); // R4
  AST_ABORT_DROPS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_abort_i |-> frame_no); // R6
  AST_REQ_QUIET_AFTER_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == MS_HALT) |=> req_no); // R8
  AST_PAR_OE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_i |=> par_oe_i); // R10
  AST_PAR_OE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ad_oe_i |=> !par_oe_i); // R10
  AST_MON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && lock_ni && frame_ni |=> !busy_i); // R11
  AST_MON_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !frame_ni |=> busy_i); // R11
  AST_OWN_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_i && !lock_ni |=> own_i); // R12
  AST_GRANT_IDLE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == MS_PARK) && gnt_ni |=> (state_i == MS_IDLE)); // R4
endmodule

bind pci_master_seq pci_master_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .state_i        (state_w),
  .busy_i         (busy_w),
  .own_i          (owned_w),
  .gnt_ni         (gnt_ni),
  .lock_ni        (lock_ni),
  .frame_ni       (frame_ni),
  .req_no         (req_no),
  .frame_no       (frame_no),
  .master_abort_i (master_abort_o),
  .ad_oe_i        (ad_oe_o),
  .par_oe_i       (par_oe_o)
);

// File: tb/sim_pci_master_seq.sv
`timescale 1ns/1ps
module sim_pci_master_seq;
  localparam int AD_W = 32;
  localparam int CBE_W = 4;
  localparam int LIM = 5;
  localparam int I_IDLE = 0, I_ADDR = 1, I_DATA = 2, I_TURN = 3, I_STOP = 4, I_PARK = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req, step, lastp, rdy, lreq, pwr, same, fb2b, latx, cmdw, perr;
  logic [AD_W-1:0] ad;
  logic [CBE_W-1:0] cbe;
  logic gnt, frm, irdy, trdy, stop, devsel, lck;
  logic req_no, frame_no, frame_oe, irdy_no, irdy_oe, lock_no, lock_oe;
  logic cbe_oe, ad_oe, park_addr, par, par_oe, perr_no, perr_oe, mabort, tabort;

  pci_master_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .step_i(step), .last_phase_i(lastp),
    .ready_i(rdy), .locked_req_i(lreq), .prev_write_i(pwr), .same_tgt_i(same),
    .fb2b_en_i(fb2b), .lat_expired_i(latx), .cmd_write_i(cmdw), .perr_report_i(perr),
    .ad_i(ad), .cbe_ni(cbe), .gnt_ni(gnt), .frame_ni(frm), .irdy_ni(irdy),
    .trdy_ni(trdy), .stop_ni(stop), .devsel_ni(devsel), .lock_ni(lck),
    .req_no(req_no), .frame_no(frame_no), .frame_oe_o(frame_oe), .irdy_no(irdy_no),
    .irdy_oe_o(irdy_oe), .lock_no(lock_no), .lock_oe_o(lock_oe), .cbe_oe_o(cbe_oe),
    .ad_oe_o(ad_oe), .park_addr_o(park_addr), .par_o(par), .par_oe_o(par_oe),
    .perr_no(perr_no), .perr_oe_o(perr_oe), .master_abort_o(mabort),
    .target_abort_o(tabort)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int m_st = I_IDLE;
  bit m_hprev = 0, m_seen = 0, m_own = 0, m_busy = 0, m_loe = 0;
  bit m_ioe = 0, m_poe = 0, m_par = 0, m_perr = 0;
  int m_cnt = 0;
  int st_hits[6];

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  function automatic bit pr(input int pct);
    return ($urandom_range(0, 99) < pct);
  endfunction

  // one clock: drive at negedge, compare, advance model at posedge
  task automatic step_cycle(input int p_gnt, input int p_frm, input int p_irdy, input int p_trdy,
                            input int p_stop, input int p_dsel, input int p_lck,
                            input int p_req, input int p_lreq, input int p_pwr);
    bit dto, e_frame_drv, e_req, e_lock_drv, e_loe;
    int nx;
    @(negedge clk);
    gnt = !pr(p_gnt); frm = !pr(p_frm); irdy = !pr(p_irdy); trdy = !pr(p_trdy);
    stop = !pr(p_stop); devsel = !pr(p_dsel); lck = !pr(p_lck);
    req = pr(p_req); step = pr(20); lastp = pr(30); rdy = pr(70); lreq = pr(p_lreq);
    pwr = pr(p_pwr); same = pr(50); fb2b = pr(50); latx = pr(30); cmdw = pr(50);
    perr = pr(5); ad = $urandom(); cbe = CBE_W'($urandom());
    #1;
    dto = (m_st == I_DATA) && !m_seen && (m_cnt >= LIM);
    e_frame_drv = (m_st == I_ADDR) ||
      ((m_st == I_DATA) && !dto && ((!lastp && (!latx || !gnt) && stop) || !rdy));
    chk("R2 R5", "frame_no", frame_no, !e_frame_drv);
    chk("R5", "irdy_no", irdy_no, !((m_st == I_DATA) && (rdy || dto)));
    chk("R6", "master_abort", mabort, (m_st == I_DATA) && dto);
    chk("R7", "target_abort", tabort, (m_st == I_DATA) && !stop && devsel && frm && !irdy);
    e_req = req && (!lreq || !m_busy) && !(m_st == I_STOP || m_hprev);
    chk("R8 R11", "req_no", req_no, !e_req);
    chk("R1 R3 R9", "frame_oe", frame_oe, (m_st == I_ADDR) || (m_st == I_DATA));
    chk("R4 R9", "cbe_oe", cbe_oe, (m_st == I_ADDR) || (m_st == I_DATA) || (m_st == I_PARK));
    chk("R9", "ad_oe", ad_oe, (m_st == I_ADDR) || ((m_st == I_DATA) && cmdw) || (m_st == I_PARK));
    chk("R9", "park_addr", park_addr, (m_st == I_PARK) && step && req);
    chk("R9", "irdy_oe", irdy_oe, m_ioe);
    chk("R10", "par", par, m_par);
    chk("R10", "par_oe", par_oe, m_poe);
    chk("R10", "perr_no", perr_no, !perr);
    chk("R10", "perr_oe", perr_oe, perr || m_perr);
    e_lock_drv = m_own && (m_st == I_DATA);
    e_loe = e_lock_drv || (m_loe && (!frm || !lck));
    chk("R12", "lock_no", lock_no, !e_lock_drv);
    chk("R12", "lock_oe", lock_oe, e_loe);
    // next state
    nx = m_st;
    case (m_st)
      I_IDLE: if (!gnt && frm && irdy) nx = (req && !step) ? I_ADDR : I_PARK;
      I_ADDR: nx = I_DATA;
      I_DATA: begin
        if (!frm || (trdy && stop && !dto)) nx = I_DATA;
        else if (!stop || dto) nx = I_STOP;
        else if (req && !step && !gnt && !trdy && pwr && (same || fb2b)) nx = I_ADDR;
        else nx = I_TURN;
      end
      I_STOP: nx = gnt ? I_IDLE : I_PARK;
      default: nx = gnt ? I_IDLE : ((req && !step) ? I_ADDR : I_PARK);
    endcase
    @(posedge clk);
    if (m_st == I_ADDR) begin m_cnt = 0; m_seen = 0; end
    else if (m_st == I_DATA) begin
      if (m_cnt < LIM) m_cnt++;
      m_seen = m_seen || !devsel;
    end
    if (m_busy) m_busy = !(lck && frm);
    else m_busy = !lck && !m_own;
    m_own = (lck && frm && irdy && !gnt && req && lreq) || (m_own && (!frm || !lck));
    m_hprev = (m_st == I_STOP);
    m_ioe = (m_st == I_ADDR) || (m_st == I_DATA);
    m_poe = (m_st == I_ADDR) || ((m_st == I_DATA) && cmdw) || (m_st == I_PARK);
    m_par = ^{ad, cbe};
    m_perr = perr;
    m_loe = e_loe;
    m_st = nx;
    st_hits[nx]++;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    req = 0; step = 0; lastp = 0; rdy = 0; lreq = 0; pwr = 0; same = 0; fb2b = 0;
    latx = 0; cmdw = 0; perr = 0; ad = '0; cbe = '0;
    gnt = 1; frm = 1; irdy = 1; trdy = 1; stop = 1; devsel = 1; lck = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset req_no", req_no, 1'b1);
    chk("R1", "reset frame_no", frame_no, 1'b1);
    chk("R1", "reset irdy_no", irdy_no, 1'b1);
    chk("R1", "reset lock_no", lock_no, 1'b1);
    chk("R1", "reset frame_oe", frame_oe, 1'b0);
    chk("R1", "reset cbe_oe", cbe_oe, 1'b0);
    chk("R1", "reset ad_oe", ad_oe, 1'b0);
    chk("R1", "reset par_oe", par_oe, 1'b0);
    chk("R1", "reset irdy_oe", irdy_oe, 1'b0);
    chk("R1", "reset lock_oe", lock_oe, 1'b0);
    rst_n = 1'b1;
    // mixed traffic
    repeat (2500) step_cycle(60, 40, 40, 40, 20, 50, 10, 60, 20, 50);
    // long data phases with a silent target: R6
    repeat (2500) step_cycle(80, 85, 30, 20, 5, 3, 5, 80, 0, 50);
    // locked requests on an idle bus: R11 R12
    repeat (2500) step_cycle(70, 35, 30, 40, 15, 60, 30, 80, 90, 50);
    // write completions with a ready target: R3 fast back-to-back
    repeat (2500) step_cycle(80, 30, 30, 80, 5, 80, 5, 90, 0, 90);
    // every state reached at least once
    for (int s = 0; s < 6; s++) begin
      checks++;
      if (st_hits[s] == 0) begin
        errors++;
        $display("FAIL R3 R4 state %0d never reached actual=0 expected>0", s);
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule